// File: doc/BRIEF.md
# SPI Serial Memory Slave Front-End

This block is the bit-level slave side of a byte-addressed serial memory. It oversamples the chip select, serial clock and serial data input on a fast system clock. Within each chip-select frame it assembles bytes most-significant bit first. It labels each byte as instruction, address or data, and reports the 24-bit address once all of it has arrived. For reads it asks the command layer for each outgoing byte and shifts that byte out on the serial output. The output pin is modelled as a value plus an output enable.

Framing follows the serial clock idling low. Input bits are taken on rising clock edges, and the output moves only after falling edges. After power-up nothing is accepted until the chip select is seen falling, so a select that is already low at power-up does not open a frame. A hardware reset input puts the interface into a quiet mode with the output released. That reset is not honoured while the command layer reports an internal cycle in progress.

Top module: `spi_mem_front`

## Requirements
- R1: Serial input is taken on each rising serial clock edge, most-significant bit first. After every eighth bit of a frame, `rx_valid` is high for exactly one system cycle with the assembled byte on `rx_data`.
- R2: `spi_miso_o` changes only in response to a falling serial clock edge, never while the serial clock is high.
- R3: `spi_miso_oe` is low whenever chip select has been high for three system cycles, and low out of reset.
- R4: After power-up (system reset), no byte is reported, no read byte is requested and the output stays disabled until a chip-select falling edge has been seen.
- R5: `rx_kind` encodes 0 for the first byte of a frame (instruction), 1 for the next three (address) and 2 for every later byte (data). `addr_valid` pulses together with the third address byte, and `addr_o` then holds the three address bytes with the first received in bits 23:16.
- R6: Chip select rising in the middle of a byte discards the partial bits. The next frame starts at bit zero.
- R7: `dev_rst_n` low while `busy_i` is low enters reset mode. In that mode the output is disabled and no bytes are reported. After `dev_rst_n` returns high, a new chip-select falling edge is needed before traffic resumes.
- R8: `dev_rst_n` low while `busy_i` is high has no effect: the frame in progress continues.
- R9: `tx_req` pulses for one cycle at frame start and each time a read byte is taken into the shifter. The taken byte (the last one written with `tx_wr`) appears MSB first. Its first bit shows up after the falling edge that ends the previous byte.
- R10: If no byte was written since the last request, the next output byte is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data input |
| dev_rst_n | input | 1 | Hardware reset pin, active low |
| busy_i | input | 1 | Internal program/erase/write cycle in progress |
| spi_miso_o | output | 1 | Serial data output value |
| spi_miso_oe | output | 1 | Serial data output enable |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_kind | output | 2 | 0 instruction, 1 address, 2 data |
| addr_valid | output | 1 | Strobe: full address received |
| addr_o | output | 24 | Assembled address |
| tx_req | output | 1 | Request for the next read byte |
| tx_wr | input | 1 | Write strobe for the next read byte |
| tx_data | input | 8 | Next read byte |

## Verification
The hardest case to reach is a frame that is live when the hardware reset arrives. The reset can land either while an internal cycle is reported busy or while none is, and the bench must show that the first case leaves the frame intact while the second kills it and keeps it dead after release. The bench opens a frame and clocks in an instruction, then lowers the reset pin with `busy_i` held at each value. It keeps clocking bytes with chip select still low, so that only the framing and reset logic decide whether those bytes are reported. A long frame then sweeps all 256 data byte values while reading back a computed pattern, which covers every output byte boundary.

// File: rtl/spi_front_pkg.sv
// Shared definitions for the serial memory slave front-end.
package spi_front_pkg;
    // Classification of a received byte by its position in the frame.
    typedef enum logic [1:0] {
        KIND_INSTR = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_DATA  = 2'd2
    } byte_kind_e;
endpackage

// File: rtl/spi_in_sync.sv
// Multi-stage synchronizer with edge detection for a bundle of async inputs.
// Assumes inputs are slow relative to clk; STAGES must be at least 2.
module spi_in_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [STAGES-1:0][W-1:0] stg_q;
    logic [W-1:0]             prev_q;

    // Shift the inputs through the synchronizer chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            stg_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign lvl  = stg_q[STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/spi_rx_frame.sv
// Receive shifter: assembles MSB-first bytes on serial clock rising events,
// classifies them by frame position and gathers the address bytes.
// Assumes frame_on drops between frames so counters restart.
module spi_rx_frame
    import spi_front_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int ADDR_BYTES = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_on,
    input  logic                         sck_rise,
    input  logic                         mosi,
    output logic                         byte_valid,
    output logic [BYTE_W-1:0]            byte_data,
    output logic [1:0]                   byte_kind,
    output logic                         addr_valid,
    output logic [ADDR_BYTES*BYTE_W-1:0] addr
);
    localparam int AW    = ADDR_BYTES * BYTE_W;
    localparam int CNT_W = $clog2(BYTE_W);
    localparam int IDX_W = $clog2(ADDR_BYTES + 2);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] IDX_ALAST = IDX_W'(ADDR_BYTES);
    localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(ADDR_BYTES + 1);

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [AW-1:0]     acc_q;
    logic [BYTE_W-1:0] new_byte;
    logic [1:0]        kind_now;

    assign new_byte = {sh_q[BYTE_W-2:0], mosi};

    // Kind of the byte completing now, from its index in the frame.
    always_comb begin
        if (idx_q == '0)            kind_now = KIND_INSTR;
        else if (idx_q <= IDX_ALAST) kind_now = KIND_ADDR;
        else                         kind_now = KIND_DATA;
    end

    // Bit counting, byte completion, index tracking and address gathering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            idx_q      <= '0;
            acc_q      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            byte_kind  <= KIND_INSTR;
            addr_valid <= 1'b0;
            addr       <= '0;
        end else begin
            byte_valid <= 1'b0;
            addr_valid <= 1'b0;
            if (!frame_on) begin
                cnt_q <= '0;
                idx_q <= '0;
            end else if (sck_rise) begin
                sh_q <= new_byte;
                if (cnt_q == CNT_LAST) begin
                    cnt_q      <= '0;
                    byte_valid <= 1'b1;
                    byte_data  <= new_byte;
                    byte_kind  <= kind_now;
                    if (idx_q != IDX_DATA) idx_q <= idx_q + 1'b1;
                    if (kind_now == KIND_ADDR) acc_q <= {acc_q[AW-BYTE_W-1:0], new_byte};
                    if (idx_q == IDX_ALAST) begin
                        addr_valid <= 1'b1;
                        addr       <= {acc_q[AW-BYTE_W-1:0], new_byte};
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_tx_shift.sv
// Transmit shifter: holds one staged read byte, requests the next, and moves
// the output bit only on serial clock falling events. Underrun sends all ones.
module spi_tx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_on,
    input  logic              frame_start,
    input  logic              sck_fall,
    input  logic              byte_done,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_req,
    output logic              miso
);
    logic [BYTE_W-1:0] hold_q;
    logic              full_q;
    logic [BYTE_W-1:0] sh_q;
    logic              wrap_q;
    logic [BYTE_W-1:0] load_byte;

    assign load_byte = full_q ? hold_q : '1;

    // Staging register, byte-boundary flag, shifter and output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            full_q <= 1'b0;
            sh_q   <= '1;
            wrap_q <= 1'b0;
            tx_req <= 1'b0;
            miso   <= 1'b1;
        end else begin
            tx_req <= 1'b0;
            if (frame_start) begin
                full_q <= 1'b0;
                wrap_q <= 1'b0;
                sh_q   <= '1;
                tx_req <= 1'b1;
            end else if (frame_on) begin
                if (byte_done) wrap_q <= 1'b1;
                if (tx_wr) begin
                    hold_q <= tx_data;
                    full_q <= 1'b1;
                end
                if (sck_fall) begin
                    if (wrap_q) begin
                        miso   <= load_byte[BYTE_W-1];
                        sh_q   <= {load_byte[BYTE_W-2:0], 1'b1};
                        full_q <= 1'b0;
                        wrap_q <= 1'b0;
                        tx_req <= 1'b1;
                    end else begin
                        miso <= sh_q[BYTE_W-1];
                        sh_q <= {sh_q[BYTE_W-2:0], 1'b1};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_mem_front.sv
// Serial memory slave front-end top. Synchronizes the pins, gates frames on a
// chip-select falling edge, applies the hardware reset unless busy, and joins
// the receive and transmit shifters. Serial clock idles low; clk >= 4x sck.
module spi_mem_front
    import spi_front_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int ADDR_BYTES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         spi_sck,
    input  logic                         spi_cs_n,
    input  logic                         spi_mosi,
    input  logic                         dev_rst_n,
    input  logic                         busy_i,
    output logic                         spi_miso_o,
    output logic                         spi_miso_oe,
    output logic                         rx_valid,
    output logic [BYTE_W-1:0]            rx_data,
    output logic [1:0]                   rx_kind,
    output logic                         addr_valid,
    output logic [ADDR_BYTES*BYTE_W-1:0] addr_o,
    output logic                         tx_req,
    input  logic                         tx_wr,
    input  logic [BYTE_W-1:0]            tx_data
);
    // Bundle order: {dev reset, data, select, clock}. Select resets low so a
    // select already low at power-up never looks like a falling edge.
    localparam int         SW      = 4;
    localparam logic [3:0] SYNC_RV = 4'b1000;

    logic [SW-1:0] s_lvl, s_rise, s_fall;
    logic sck_rise, sck_fall, cs_lvl, cs_fall, mosi_s, drst_lvl;
    logic rst_mode, frame_on, frame_start;

    spi_in_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RV)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({dev_rst_n, spi_mosi, spi_cs_n, spi_sck}),
        .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
    );

    assign sck_rise = s_rise[0];
    assign sck_fall = s_fall[0];
    assign cs_lvl   = s_lvl[1];
    assign cs_fall  = s_fall[1];
    assign mosi_s   = s_lvl[2];
    assign drst_lvl = s_lvl[3];

    assign frame_start = cs_fall & ~rst_mode;

    // Reset mode: entered on reset pin low only when no internal cycle runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rst_mode <= 1'b0;
        else if (!drst_lvl && !busy_i) rst_mode <= 1'b1;
        else if (drst_lvl)             rst_mode <= 1'b0;
    end

    // Frame gate: opened only by a select falling edge, closed by select high.
    always_ff @(posedge clk) begin
        if (!rst_n)          frame_on <= 1'b0;
        else if (rst_mode)   frame_on <= 1'b0;
        else if (cs_fall)    frame_on <= 1'b1;
        else if (cs_lvl)     frame_on <= 1'b0;
    end

    assign spi_miso_oe = frame_on & ~rst_mode;

    spi_rx_frame #(.BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES)) u_rx (
        .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .sck_rise(sck_rise),
        .mosi(mosi_s), .byte_valid(rx_valid), .byte_data(rx_data),
        .byte_kind(rx_kind), .addr_valid(addr_valid), .addr(addr_o)
    );

    spi_tx_shift #(.BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .frame_start(frame_start),
        .sck_fall(sck_fall), .byte_done(rx_valid), .tx_wr(tx_wr),
        .tx_data(tx_data), .tx_req(tx_req), .miso(spi_miso_o)
    );
endmodule

// File: rtl/spi_front_chk.sv
// Property checker for spi_mem_front, attached by bind below.
module spi_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_miso_o,
    input logic       spi_miso_oe,
    input logic       rx_valid,
    input logic [1:0] rx_kind,
    input logic       addr_valid,
    input logic       tx_req,
    input logic       busy_i,
    input logic       sck_fall_w,
    input logic       rst_mode_w
);
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R1
    AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(spi_miso_o) |-> $past(sck_fall_w)); // R2
    AST_OE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) ($past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe); // R3
    AST_ADDR_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n) addr_valid |-> (rx_valid && rx_kind == 2'd1)); // R5
    AST_RSTMODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) rst_mode_w |=> !spi_miso_oe); // R7
    AST_BUSY_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n) (busy_i && !rst_mode_w) |=> !rst_mode_w); // R8
    AST_TXREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) tx_req |=> !tx_req); // R9
endmodule

bind spi_mem_front spi_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_o(spi_miso_o),
    .spi_miso_oe(spi_miso_oe), .rx_valid(rx_valid), .rx_kind(rx_kind),
    .addr_valid(addr_valid), .tx_req(tx_req), .busy_i(busy_i),
    .sck_fall_w(sck_fall), .rst_mode_w(rst_mode)
);

// File: tb/sim_spi_mem_front.sv
module sim_spi_mem_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b0, spi_mosi = 1'b0;
    logic dev_rst_n = 1'b1, busy_i = 1'b0;
    logic spi_miso_o, spi_miso_oe, rx_valid, addr_valid, tx_req;
    logic [7:0] rx_data;
    logic [1:0] rx_kind;
    logic [23:0] addr_o;
    logic tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;

    int checks = 0, fails = 0;
    int rx_n = 0, addr_n = 0, req_n = 0, tx_n = 0, viol = 0;
    bit resp_en = 1'b1;
    logic [7:0] rx_q [0:511];
    logic [1:0] kind_q [0:511];
    logic [23:0] last_addr = '0;
    logic [7:0] mo [0:299];

    always #2 clk = ~clk;

    spi_mem_front u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .dev_rst_n(dev_rst_n), .busy_i(busy_i),
        .spi_miso_o(spi_miso_o), .spi_miso_oe(spi_miso_oe), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_kind(rx_kind), .addr_valid(addr_valid),
        .addr_o(addr_o), .tx_req(tx_req), .tx_wr(tx_wr), .tx_data(tx_data)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'(k) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Monitors: received bytes, address strobes, requests, output-change timing.
    initial begin
        logic prev_m = 1'b1;
        forever begin
            @(negedge clk);
            if (rx_valid) begin rx_q[rx_n] = rx_data; kind_q[rx_n] = rx_kind; rx_n++; end
            if (addr_valid) begin last_addr = addr_o; addr_n++; end
            if (rst_n && spi_miso_o !== prev_m && spi_sck) viol++;
            prev_m = spi_miso_o;
        end
    end

    // Read-data responder: answers each request with the next pattern byte.
    initial begin
        forever begin
            @(negedge clk);
            if (tx_req) req_n++;
            if (tx_req && resp_en) begin tx_data = pat(tx_n); tx_wr = 1'b1; tx_n++; end
            else tx_wr = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    task automatic xfer(input logic [7:0] b, output logic [7:0] m);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = b[i];
            repeat (8) @(negedge clk);
            m[i] = spi_miso_o;
            spi_sck = 1'b1;
            repeat (8) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic sel();
        @(negedge clk); spi_cs_n = 1'b0; repeat (8) @(negedge clk);
    endtask

    task automatic desel();
        repeat (8) @(negedge clk); spi_cs_n = 1'b1; repeat (8) @(negedge clk);
    endtask

    initial begin
        logic [7:0] m;
        int base;
        logic [23:0] alist [3];
        alist[0] = 24'h000000; alist[1] = 24'hFFFFFF; alist[2] = 24'h800001;

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(spi_miso_oe == 1'b0 && rx_valid == 1'b0 && tx_req == 1'b0, "R3 reset state", spi_miso_oe, 0);

        // R4: select low since power-up, no falling edge seen yet.
        xfer(8'hA5, m); xfer(8'h3C, m);
        repeat (8) @(negedge clk);
        chk(rx_n == 0, "R4 no bytes before arming", rx_n, 0);
        chk(req_n == 0, "R4 no requests before arming", req_n, 0);
        chk(spi_miso_oe == 1'b0, "R4 output off before arming", spi_miso_oe, 0);

        // Long frame: instruction, address, all 256 data values; read pattern back.
        desel(); tx_n = 0; req_n = 0; rx_n = 0;
        sel();
        chk(spi_miso_oe == 1'b1, "R3 output on in frame", spi_miso_oe, 1);
        xfer(8'h03, mo[0]); xfer(8'h12, mo[1]); xfer(8'h34, mo[2]); xfer(8'h56, mo[3]);
        for (int j = 0; j < 256; j++) xfer(8'(j), mo[4+j]);
        desel();
        chk(spi_miso_oe == 1'b0, "R3 output off after deselect", spi_miso_oe, 0);
        chk(rx_n == 260, "R1 byte count", rx_n, 260);
        chk(rx_q[0] == 8'h03 && kind_q[0] == 2'd0, "R5 instruction byte", rx_q[0], 8'h03);
        for (int k = 1; k < 4; k++) chk(kind_q[k] == 2'd1, "R5 address kind", kind_q[k], 1);
        chk(addr_n == 1 && last_addr == 24'h123456, "R5 address value", last_addr, 24'h123456);
        for (int j = 0; j < 256; j++)
            chk(rx_q[4+j] == 8'(j) && kind_q[4+j] == 2'd2, "R1 data byte", rx_q[4+j], j);
        for (int s = 1; s < 260; s++) chk(mo[s] == pat(s-1), "R9 read byte", mo[s], pat(s-1));
        chk(req_n == 261, "R9 request count", req_n, 261);
        chk(viol == 0, "R2 output moved while clock high", viol, 0);

        // R5: address corners.
        for (int a = 0; a < 3; a++) begin
            addr_n = 0; tx_n = 0;
            sel();
            xfer(8'h0B, m); xfer(alist[a][23:16], m); xfer(alist[a][15:8], m); xfer(alist[a][7:0], m);
            xfer(8'h00, m);
            desel();
            chk(addr_n == 1 && last_addr == alist[a], "R5 address corner", last_addr, alist[a]);
        end

        // R6: abort a partial byte.
        sel();
        for (int i = 0; i < 5; i++) begin
            spi_mosi = 1'b1; repeat (8) @(negedge clk); spi_sck = 1'b1;
            repeat (8) @(negedge clk); spi_sck = 1'b0;
        end
        desel();
        base = rx_n;
        sel(); xfer(8'hC3, m); desel();
        chk(rx_n == base + 1 && rx_q[base] == 8'hC3 && kind_q[base] == 2'd0, "R6 restart after abort", rx_q[base], 8'hC3);

        // R10: no responses, all output bytes are ones.
        resp_en = 1'b0;
        sel();
        for (int k = 0; k < 6; k++) xfer(8'(k * 37), mo[k]);
        desel();
        for (int s = 1; s < 6; s++) chk(mo[s] == 8'hFF, "R10 underrun byte", mo[s], 8'hFF);
        resp_en = 1'b1;

        // R7: reset with no internal cycle.
        sel(); xfer(8'h9F, m);
        dev_rst_n = 1'b0; repeat (10) @(negedge clk);
        chk(spi_miso_oe == 1'b0, "R7 output off in reset mode", spi_miso_oe, 0);
        base = rx_n;
        xfer(8'h11, m);
        dev_rst_n = 1'b1; repeat (10) @(negedge clk);
        xfer(8'h22, m); repeat (8) @(negedge clk);
        chk(rx_n == base, "R7 no bytes in or after reset", rx_n, base);
        chk(spi_miso_oe == 1'b0, "R7 needs new select edge", spi_miso_oe, 0);
        desel(); sel(); xfer(8'h33, m); desel();
        chk(rx_n == base + 1 && rx_q[base] == 8'h33 && kind_q[base] == 2'd0, "R7 resumes after new edge", rx_q[base], 8'h33);

        // R8: reset while busy is ignored.
        busy_i = 1'b1;
        base = rx_n;
        sel(); xfer(8'h02, m);
        dev_rst_n = 1'b0; repeat (10) @(negedge clk);
        chk(spi_miso_oe == 1'b1, "R8 output stays on while busy", spi_miso_oe, 1);
        xfer(8'h44, m);
        dev_rst_n = 1'b1; repeat (10) @(negedge clk);
        busy_i = 1'b0;
        desel();
        chk(rx_n == base + 2 && rx_q[base+1] == 8'h44 && kind_q[base+1] == 2'd1, "R8 frame continues", rx_q[base+1], 8'h44);

        finish_up();
    end
endmodule